// File: doc/BRIEF.md
# Hardware Task Time-Slot Sequencer

This block chooses, on every clock, which of four hardware tasks may issue an instruction in a single processor core. Software programs a 32-bit pattern word of sixteen 2-bit slot entries, each naming a task, together with a 4-bit loop length. The sequencer holds the schedule as a ring of 2-bit stages and rotates through the active slots. It presents the task that owns the current slot as `task_id_o`.

The block also gives software a direct view of the schedule, so that no program has to decode the word itself. It returns the last written word and length unchanged. It reports a 4-bit mask of the tasks that own at least one active slot, a packed 4-bit slot count for each task, and a flag for single-task operation. A new word never cuts a loop short: it is armed, and the ring reloads from slot 0 once the running loop has issued its last slot.

The controller has two states. `ST_RUN` rotates the ring with nothing pending. `ST_ARMED` holds a written word that is waiting for the loop boundary. A write moves `ST_RUN` to `ST_ARMED`, and a further write keeps the block in `ST_ARMED`. The edge on which the ring shows its last slot performs the reload and moves `ST_ARMED` back to `ST_RUN`, unless a write arrives on that same edge.

Top module: `task_slot_seq`

## Requirements
- R1: After reset the readback word is 0 and the readback length field is 15. Task 0 issues on every cycle. The mask is 4'b0001, every count field is 0, and the single-task flag is 1.
- R2: Slot k of the word occupies bits [2k+1:2k]. With length field L, the issued task follows slots 0, 1, ..., L, one slot per cycle, and then returns to slot 0.
- R3: When L is below 15, the fields above slot L are never issued and have no effect on the mask, the counts or the single-task flag.
- R4: A write is armed and does not change the running loop. In the cycle after the running loop issues slot L, the new pattern starts at its slot 0. If several writes arrive before that boundary, the last one is used. A write on the boundary edge itself is applied at the following boundary.
- R5: From the cycle after a write, `rd_word_o` and `rd_len_o` equal the written word and length and hold them until the next write.
- R6: One cycle after the readback changes, bit n of `run_mask_o` is 1 exactly when task n owns at least one active slot.
- R7: Bits [4n+3:4n] of `slot_counts_o` hold the number of active slots that task n owns, with the same one-cycle latency. A count of 16 is shown as 0, and that case is told apart from no slots by the mask bit.
- R8: `single_task_o` is 1 exactly when every active slot belongs to task 0, which includes a written word of zero.
- R9: A pattern that gives one task a single slot in a 16-slot loop issues that task exactly once in every 16 cycles. The other tasks issue in the remaining cycles in the order the pattern gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the pattern word and length |
| wr_word_i | input | 32 | Pattern word, sixteen 2-bit task fields |
| wr_len_i | input | 4 | Number of active slots minus one |
| rd_word_o | output | 32 | Last written pattern word |
| rd_len_o | output | 4 | Last written length field |
| task_id_o | output | 2 | Task that owns the current slot |
| run_mask_o | output | 4 | Tasks that own at least one active slot |
| slot_counts_o | output | 16 | Per-task slot count, 4 bits per task, 16 shown as 0 |
| single_task_o | output | 1 | All active slots belong to task 0 |

## Verification
A scoreboard predicts the issued task for every cycle, so writes that land in the middle of a loop, back to back, or exactly on the boundary edge are all compared with the rule that the running loop must finish first. A design that reloaded at once, or that reloaded from the first of two writes, would issue the wrong task in the cycles around the boundary. Short loops whose upper fields hold other tasks catch a decoder that ignores the length: it would set extra mask bits and inflate the counts. A one-slot loop, an all-zero word, and a single task given all sixteen slots exercise the smallest ring, the single-task flag, and the count that wraps to 0 while its mask bit stays 1.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
    parameter int unsigned TASKS = 4;
    parameter int unsigned SLOTS = 16;

    localparam int unsigned ID_W   = $clog2(TASKS);
    localparam int unsigned LEN_W  = $clog2(SLOTS);
    localparam int unsigned WORD_W = SLOTS * ID_W;
    localparam int unsigned CNT_W  = LEN_W;
    localparam int unsigned CNTS_W = TASKS * CNT_W;

    typedef logic [ID_W-1:0] task_id_t;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_ARMED = 1'b1
    } seq_state_e;
endpackage

// File: rtl/tsq_slot_ring.sv
module tsq_slot_ring
    import tsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] load_word_i,
    input  logic [LEN_W-1:0]  load_len_i,
    output task_id_t          cur_task_o,
    output logic              at_last_o
);
    task_id_t           stage_q [SLOTS];
    logic [LEN_W-1:0]   len_q;
    logic [LEN_W-1:0]   pos_q;

    // each stage either takes a fresh field, passes its neighbour's entry
    // down the ring, or (as the tail) takes the head entry back
    for (genvar i = 0; i < SLOTS; i++) begin : g_stage
        task_id_t feed;
        if (i == SLOTS - 1) begin : g_tail
            assign feed = stage_q[0];
        end else begin : g_body
            assign feed = (LEN_W'(i) == len_q) ? stage_q[0] : stage_q[i+1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[i] <= '0;
            end else if (load_i) begin
                stage_q[i] <= load_word_i[i*ID_W +: ID_W];
            end else if (LEN_W'(i) <= len_q) begin
                stage_q[i] <= feed;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= LEN_W'(SLOTS - 1);
            pos_q <= '0;
        end else if (load_i) begin
            len_q <= load_len_i;
            pos_q <= '0;
        end else if (pos_q == len_q) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
        end
    end

    assign cur_task_o = stage_q[0];
    assign at_last_o  = (pos_q == len_q);
endmodule

// File: rtl/tsq_share_decoder.sv
module tsq_share_decoder
    import tsq_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [TASKS-1:0]  mask_o,
    output logic [CNTS_W-1:0] counts_o,
    output logic              single_o
);
    logic [LEN_W:0] tally [TASKS];

    always_comb begin
        for (int t = 0; t < TASKS; t++) begin
            tally[t] = '0;
        end
        for (int s = 0; s < SLOTS; s++) begin
            if (LEN_W'(s) <= len_i) begin
                tally[word_i[s*ID_W +: ID_W]] =
                    tally[word_i[s*ID_W +: ID_W]] + (LEN_W+1)'(1);
            end
        end
    end

    for (genvar t = 0; t < TASKS; t++) begin : g_task
        assign mask_o[t]                    = (tally[t] != '0);
        assign counts_o[t*CNT_W +: CNT_W]   = tally[t][CNT_W-1:0];
    end

    assign single_o = (tally[0] == ({1'b0, len_i} + (LEN_W+1)'(1)));
endmodule

// File: rtl/task_slot_seq.sv
module task_slot_seq
    import tsq_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  logic [tsq_pkg::WORD_W-1:0]    wr_word_i,
    input  logic [tsq_pkg::LEN_W-1:0]     wr_len_i,
    output logic [tsq_pkg::WORD_W-1:0]    rd_word_o,
    output logic [tsq_pkg::LEN_W-1:0]     rd_len_o,
    output logic [tsq_pkg::ID_W-1:0]      task_id_o,
    output logic [tsq_pkg::TASKS-1:0]     run_mask_o,
    output logic [tsq_pkg::CNTS_W-1:0]    slot_counts_o,
    output logic                          single_task_o
);
    seq_state_e         state_q, state_d;
    logic [WORD_W-1:0]  shadow_word_q;
    logic [LEN_W-1:0]   shadow_len_q;
    logic               at_last;
    logic               reload;
    task_id_t           ring_task;

    logic [TASKS-1:0]   dec_mask;
    logic [CNTS_W-1:0]  dec_counts;
    logic               dec_single;

    logic [TASKS-1:0]   mask_q;
    logic [CNTS_W-1:0]  counts_q;
    logic               single_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (wr_en_i) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (wr_en_i)      state_d = ST_ARMED;
                else if (at_last) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // state register and the shadow copy of the written word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q       <= ST_RUN;
            shadow_word_q <= '0;
            shadow_len_q  <= LEN_W'(SLOTS - 1);
        end else begin
            state_q <= state_d;
            if (wr_en_i) begin
                shadow_word_q <= wr_word_i;
                shadow_len_q  <= wr_len_i;
            end
        end
    end

    // per-state outputs: reload the ring only at a loop boundary
    always_comb begin
        reload = 1'b0;
        unique case (state_q)
            ST_RUN:   reload = 1'b0;
            ST_ARMED: reload = at_last;
            default:  reload = 1'b0;
        endcase
    end

    tsq_slot_ring u_ring (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (reload),
        .load_word_i (shadow_word_q),
        .load_len_i  (shadow_len_q),
        .cur_task_o  (ring_task),
        .at_last_o   (at_last)
    );

    tsq_share_decoder u_dec (
        .word_i   (shadow_word_q),
        .len_i    (shadow_len_q),
        .mask_o   (dec_mask),
        .counts_o (dec_counts),
        .single_o (dec_single)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= TASKS'(1);
            counts_q <= CNTS_W'(CNT_W'(SLOTS));
            single_q <= 1'b1;
        end else begin
            mask_q   <= dec_mask;
            counts_q <= dec_counts;
            single_q <= dec_single;
        end
    end

    assign rd_word_o     = shadow_word_q;
    assign rd_len_o      = shadow_len_q;
    assign task_id_o     = ring_task;
    assign run_mask_o    = mask_q;
    assign slot_counts_o = counts_q;
    assign single_task_o = single_q;
endmodule

// File: rtl/task_slot_seq_chk.sv
module task_slot_seq_chk
    import tsq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [WORD_W-1:0] wr_word_i,
    input logic [LEN_W-1:0]  wr_len_i,
    input logic [WORD_W-1:0] rd_word_o,
    input logic [LEN_W-1:0]  rd_len_o,
    input logic [TASKS-1:0]  run_mask_o,
    input logic              single_task_o
);
    assert_readback_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (rd_word_o == $past(wr_word_i)) && (rd_len_o == $past(wr_len_i)));

    assert_readback_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(rd_word_o) && $stable(rd_len_o));

    assert_mask_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(run_mask_o) >= 1);

    assert_single_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        single_task_o |-> (run_mask_o == TASKS'(1)));
endmodule

bind task_slot_seq task_slot_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en_i       (wr_en_i),
    .wr_word_i     (wr_word_i),
    .wr_len_i      (wr_len_i),
    .rd_word_o     (rd_word_o),
    .rd_len_o      (rd_len_o),
    .run_mask_o    (run_mask_o),
    .single_task_o (single_task_o)
);

// File: tb/task_slot_seq_tb.sv
`timescale 1ns/1ps
module task_slot_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_word = '0;
    logic [3:0]  wr_len = '0;
    logic [31:0] rd_word;
    logic [3:0]  rd_len;
    logic [1:0]  task_id;
    logic [3:0]  run_mask;
    logic [15:0] slot_counts;
    logic        single_task;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    logic [31:0] m_word = '0;
    logic [3:0]  m_len = 4'd15;
    bit          m_armed = 1'b0;
    logic [31:0] m_aw = '0;
    logic [3:0]  m_al = 4'd15;
    logic [3:0]  m_pos = '0;
    logic [1:0]  exp_q [$];

    always #5 clk = ~clk;

    task_slot_seq u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (wr_en),
        .wr_word_i     (wr_word),
        .wr_len_i      (wr_len),
        .rd_word_o     (rd_word),
        .rd_len_o      (rd_len),
        .task_id_o     (task_id),
        .run_mask_o    (run_mask),
        .slot_counts_o (slot_counts),
        .single_task_o (single_task)
    );

    // driver side of the scoreboard: predict the task for the next cycle
    always @(posedge clk) begin
        if (rst_n) begin
            bit at_end;
            at_end = (m_pos == m_al);
            if (m_armed && at_end) begin
                m_aw  = m_word;
                m_al  = m_len;
                m_pos = '0;
                m_armed = 1'b0;
            end else begin
                m_pos = at_end ? 4'd0 : m_pos + 4'd1;
            end
            if (wr_en) begin
                m_word  = wr_word;
                m_len   = wr_len;
                m_armed = 1'b1;
            end
            exp_q.push_back(m_aw[2*m_pos +: 2]);
        end
    end

    // monitor side: compare away from the clock edge (R2, R3, R4, R9)
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            logic [1:0] e;
            e = exp_q.pop_front();
            checks++;
            if (task_id !== e) begin
                failures++;
                $display("FAIL R2/R3/R4/R9 task_id actual=%0d expected=%0d t=%0t", task_id, e, $time);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_status(input logic [31:0] w, input logic [3:0] l);
        logic [4:0]  n [4];
        logic [3:0]  em;
        logic [15:0] ec;
        for (int t = 0; t < 4; t++) n[t] = '0;
        for (int s = 0; s <= int'(l); s++) n[w[2*s +: 2]] = n[w[2*s +: 2]] + 5'd1;
        for (int t = 0; t < 4; t++) begin
            em[t] = (n[t] != 0);
            ec[4*t +: 4] = n[t][3:0];
        end
        chk("R5 rd_word", rd_word, w);
        chk("R5 rd_len", {28'd0, rd_len}, {28'd0, l});
        chk("R6 run_mask", {28'd0, run_mask}, {28'd0, em});
        chk("R7 slot_counts", {16'd0, slot_counts}, {16'd0, ec});
        chk("R8 single_task", {31'd0, single_task}, {31'd0, (n[0] == 5'(l) + 5'd1)});
    endtask

    task automatic do_write(input logic [31:0] w, input logic [3:0] l);
        @(negedge clk);
        wr_en = 1'b1; wr_word = w; wr_len = l;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic write_and_check(input logic [31:0] w, input logic [3:0] l, input int run);
        do_write(w, l);
        @(negedge clk);
        check_status(w, l);
        repeat (run) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 task_id", {30'd0, task_id}, 32'd0);
        chk("R1 rd_word", rd_word, 32'd0);
        chk("R1 rd_len", {28'd0, rd_len}, 32'd15);
        chk("R1 run_mask", {28'd0, run_mask}, 32'd1);
        chk("R1 slot_counts", {16'd0, slot_counts}, 32'd0);
        chk("R1 single_task", {31'd0, single_task}, 32'd1);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        // R2: all four tasks in a full loop
        write_and_check(32'hE4E4_E4E4, 4'd15, 40);
        // R3: three active slots, upper fields name task 3
        write_and_check(32'hFFFF_FF19, 4'd2, 30);
        // R9: task 3 gets one slot in sixteen
        write_and_check(32'h5555_5557, 4'd15, 50);
        // R8: zero word gives single-task mode
        write_and_check(32'h0000_0000, 4'd15, 20);
        // R3: one-slot loop on task 2
        write_and_check(32'hFFFF_FFFE, 4'd0, 20);
        // R7: task 1 owns all sixteen slots, count wraps to 0
        write_and_check(32'h5555_5555, 4'd15, 20);
        // R4: two writes before the boundary, last one wins
        do_write(32'h0000_00B1, 4'd3);
        do_write(32'h0000_0036, 4'd4);
        @(negedge clk);
        check_status(32'h0000_0036, 4'd4);
        repeat (40) @(negedge clk);
        // R4: writes on consecutive cycles around short-loop boundaries
        write_and_check(32'h0000_0009, 4'd1, 3);
        @(negedge clk);
        wr_en = 1'b1; wr_word = 32'h0000_000E; wr_len = 4'd1;
        @(negedge clk);
        wr_word = 32'h0000_0027; wr_len = 4'd2;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        check_status(32'h0000_0027, 4'd2);
        repeat (30) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule